// File: doc/BRIEF.md
# Multipath Hash Member Selector

This block picks one member of an equal-cost multipath group or link-aggregation group for each packet. It hashes the packet's address fields so that every packet of one flow takes the same path. The caller supplies the parsed destination and source MAC addresses, IPv4 addresses and layer-4 ports. A three-bit enable mask switches the layer-2, layer-3 and layer-4 field pairs into the hash one pair at a time. Each request also carries the number of hash bits to use and the group size.

The hash is a Pearson hash computed one byte per clock. The running value starts at zero. For each key byte, the running value is XORed with that byte and the result indexes a 256-entry byte permutation table; the table entry becomes the new running value. The table can be written at run time. Each write is carried out as a swap, so the table always remains a true permutation. The low hash bits, reduced modulo the group size, give the member index. The 8-bit hash is also output.

Top module: `mp_hash_sel`

## Requirements
- R1: After reset the permutation table is the identity (entry i holds i), `busy_o` and `valid_o` are low, and `hash_o` is zero.
- R2: The key is 24 bytes, taken most significant byte first in this order: destination MAC, source MAC, destination IP, source IP, destination port, source port. Starting from zero, each byte sets hash to T[hash XOR byte].
- R3: `field_en_i` bit 0 enables the two MACs, bit 1 the two IPs and bit 2 the two ports. A disabled pair contributes zero bytes in its positions, so the key length does not change.
- R4: A request is accepted on a clock edge where `req_i` is high and `busy_o` is low. `valid_o` is high for exactly one cycle, 24 clock edges after the accepting edge. `busy_o` is high from the accepting edge until `valid_o` rises.
- R5: Only the low `hash_bits_i` bits of the hash (values of 8 or more mean all 8 bits) are used for member selection. A value of 0 always selects member 0.
- R6: `member_o` equals the masked hash modulo the group size. A group size of 0 or 1 selects member 0. Sizes above 16 are treated as 16.
- R7: A table write of value v at address a sets T[a]=v and moves the previous T[a] to the entry that held v. The table therefore stays a permutation.
- R8: Table writes issued while `busy_o` is high are ignored.
- R9: `req_i` while `busy_o` is high is ignored. It produces no extra result and does not disturb the hash in progress.
- R10: Identical field values and configuration always give an identical hash and member.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start a hash of the presented fields |
| field_en_i | input | 3 | Enables for the L2, L3 and L4 field pairs |
| dst_mac_i | input | 48 | Destination MAC address |
| src_mac_i | input | 48 | Source MAC address |
| dst_ip_i | input | 32 | Destination IP address |
| src_ip_i | input | 32 | Source IP address |
| dst_port_i | input | 16 | Destination L4 port |
| src_port_i | input | 16 | Source L4 port |
| hash_bits_i | input | 4 | Number of hash bits used for selection |
| group_size_i | input | 5 | Number of members in the group |
| tbl_we_i | input | 1 | Permutation table write strobe |
| tbl_addr_i | input | 8 | Table write address |
| tbl_data_i | input | 8 | Table write value |
| busy_o | output | 1 | Hash in progress |
| valid_o | output | 1 | Result valid pulse |
| hash_o | output | 8 | Flow hash |
| member_o | output | 4 | Selected member index |

## Verification
Each accepted request gives a result exactly 24 edges after the edge that accepts it; `hash_o` and `member_o` are valid in the cycle where `valid_o` is high. The driver records the cycle count of the accepting edge together with the expected hash and member. The monitor samples on the falling edge, pops the oldest entry on each `valid_o` and checks that the distance is exactly 24. A result that arrives with an empty queue counts as a failure, which is how requests that should be ignored while busy are caught. The outcome of ignored table writes shows up in the hashes of later requests.

// File: rtl/mph_pkg.sv
package mph_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned TBL_DEPTH = 1 << BYTE_W;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/mph_perm_table.sv
module mph_perm_table
  import mph_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  byte_t wr_addr_i,
  input  byte_t wr_data_i,
  input  byte_t rd_addr_i,
  output byte_t rd_data_o
);
  byte_t fwd_q [TBL_DEPTH];
  byte_t inv_q [TBL_DEPTH];
  byte_t old_val, old_pos;

  assign old_val   = fwd_q[wr_addr_i];
  assign old_pos   = inv_q[wr_data_i];
  assign rd_data_o = fwd_q[rd_addr_i];

  // swap write keeps fwd a permutation and inv its inverse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TBL_DEPTH; i++) begin
        fwd_q[i] <= byte_t'(i);
        inv_q[i] <= byte_t'(i);
      end
    end else if (we_i) begin
      fwd_q[old_pos]   <= old_val;
      fwd_q[wr_addr_i] <= wr_data_i;
      inv_q[old_val]   <= old_pos;
      inv_q[wr_data_i] <= wr_addr_i;
    end
  end

  a_r7_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (fwd_q[$past(wr_addr_i)] == $past(wr_data_i)) &&
             (inv_q[$past(wr_data_i)] == $past(wr_addr_i)));
  a_r7_inverse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_q[rd_data_o] == rd_addr_i);
endmodule

// File: rtl/mph_pearson_core.sv
module mph_pearson_core
  import mph_pkg::*;
#(
  parameter int unsigned KEY_W = 192
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [KEY_W-1:0] key_i,
  input  byte_t            rd_data_i,
  output byte_t            rd_addr_o,
  output logic             busy_o,
  output logic             done_o,
  output byte_t            hash_o
);
  localparam int unsigned KEY_BYTES = KEY_W / BYTE_W;
  localparam int unsigned CNT_W     = $clog2(KEY_BYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(KEY_BYTES - 1);

  logic [KEY_W-1:0] key_q;
  logic [CNT_W-1:0] cnt_q;
  byte_t            hash_q;
  logic             busy_q, done_q;

  assign rd_addr_o = hash_q ^ key_q[KEY_W-1 -: BYTE_W];
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign hash_o    = hash_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q  <= '0;
      cnt_q  <= '0;
      hash_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        key_q  <= key_i;
        cnt_q  <= '0;
        hash_q <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        hash_q <= rd_data_i;
        key_q  <= key_q << BYTE_W;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> hash_q == $past(rd_data_i));
  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r4_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q && $past(busy_q));
  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && cnt_q != LAST) |=> busy_q && cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/mph_reduce.sv
module mph_reduce
  import mph_pkg::*;
#(
  parameter int unsigned MAX_WAYS = 16,
  localparam int unsigned SIZE_W  = $clog2(MAX_WAYS) + 1,
  localparam int unsigned MEM_W   = $clog2(MAX_WAYS)
) (
  input  byte_t             hash_i,
  input  logic [3:0]        bits_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [MEM_W-1:0]  member_o
);
  byte_t             mask, masked;
  logic [SIZE_W-1:0] size_eff;
  logic [BYTE_W-1:0] rem;

  always_comb begin
    mask     = (bits_i >= 4'(BYTE_W)) ? '1 : byte_t'((9'd1 << bits_i) - 9'd1);
    masked   = hash_i & mask;
    size_eff = (size_i > SIZE_W'(MAX_WAYS)) ? SIZE_W'(MAX_WAYS) : size_i;
    rem      = (size_eff <= SIZE_W'(1)) ? '0 : masked % BYTE_W'(size_eff);
    member_o = MEM_W'(rem);
  end
endmodule

// File: rtl/mp_hash_sel.sv
module mp_hash_sel
  import mph_pkg::*;
#(
  parameter int unsigned MAC_W    = 48,
  parameter int unsigned IP_W     = 32,
  parameter int unsigned PORT_W   = 16,
  parameter int unsigned MAX_WAYS = 16,
  localparam int unsigned SIZE_W  = $clog2(MAX_WAYS) + 1,
  localparam int unsigned MEM_W   = $clog2(MAX_WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        field_en_i,
  input  logic [MAC_W-1:0]  dst_mac_i,
  input  logic [MAC_W-1:0]  src_mac_i,
  input  logic [IP_W-1:0]   dst_ip_i,
  input  logic [IP_W-1:0]   src_ip_i,
  input  logic [PORT_W-1:0] dst_port_i,
  input  logic [PORT_W-1:0] src_port_i,
  input  logic [3:0]        hash_bits_i,
  input  logic [SIZE_W-1:0] group_size_i,
  input  logic              tbl_we_i,
  input  logic [7:0]        tbl_addr_i,
  input  logic [7:0]        tbl_data_i,
  output logic              busy_o,
  output logic              valid_o,
  output logic [7:0]        hash_o,
  output logic [MEM_W-1:0]  member_o
);
  localparam int unsigned KEY_W = 2 * (MAC_W + IP_W + PORT_W);

  logic [KEY_W-1:0]  key;
  logic              accept, busy;
  byte_t             rd_addr, rd_data;
  logic [3:0]        bits_q;
  logic [SIZE_W-1:0] size_q;

  // disabled pairs become zero bytes; key length is fixed
  assign key = {field_en_i[0] ? dst_mac_i  : '0, field_en_i[0] ? src_mac_i  : '0,
                field_en_i[1] ? dst_ip_i   : '0, field_en_i[1] ? src_ip_i   : '0,
                field_en_i[2] ? dst_port_i : '0, field_en_i[2] ? src_port_i : '0};

  assign accept = req_i && !busy;
  assign busy_o = busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
      size_q <= '0;
    end else if (accept) begin
      bits_q <= hash_bits_i;
      size_q <= group_size_i;
    end
  end

  mph_perm_table i_table (
    .clk_i, .rst_ni,
    .we_i     (tbl_we_i && !busy),
    .wr_addr_i(tbl_addr_i),
    .wr_data_i(tbl_data_i),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );

  mph_pearson_core #(.KEY_W(KEY_W)) i_core (
    .clk_i, .rst_ni,
    .start_i  (req_i),
    .key_i    (key),
    .rd_data_i(rd_data),
    .rd_addr_o(rd_addr),
    .busy_o   (busy),
    .done_o   (valid_o),
    .hash_o   (hash_o)
  );

  mph_reduce #(.MAX_WAYS(MAX_WAYS)) i_reduce (
    .hash_i  (hash_o),
    .bits_i  (bits_q),
    .size_i  (size_q),
    .member_o(member_o)
  );

  a_r6_size_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && size_q <= SIZE_W'(1)) |-> member_o == '0);
  a_r6_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && size_q > SIZE_W'(1)) |-> SIZE_W'(member_o) < size_q);
  a_r5_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && bits_q == '0) |-> member_o == '0);
  a_r4_busy_on_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o);
endmodule

// File: tb/test_mp_hash_sel.sv
`timescale 1ns/1ps
module test_mp_hash_sel;
  localparam int KEY_BYTES = 24;

  logic clk = 0, rst_n = 0;
  logic req = 0, tbl_we = 0;
  logic [2:0]  en = 0;
  logic [47:0] dmac = 0, smac = 0;
  logic [31:0] dip = 0, sip = 0;
  logic [15:0] dport = 0, sport = 0;
  logic [3:0]  hbits = 0;
  logic [4:0]  gsize = 0;
  logic [7:0]  taddr = 0, tdata = 0;
  logic        busy, valid;
  logic [7:0]  hash;
  logic [3:0]  member;

  int checks = 0, errors = 0, cyc = 0;

  typedef struct { logic [7:0] h; logic [3:0] m; int acc; string tag; } exp_t;
  exp_t sb[$];

  logic [7:0] m_fwd [256];
  logic [7:0] m_inv [256];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mp_hash_sel i_mp_hash_sel (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .field_en_i(en),
    .dst_mac_i(dmac), .src_mac_i(smac), .dst_ip_i(dip), .src_ip_i(sip),
    .dst_port_i(dport), .src_port_i(sport), .hash_bits_i(hbits),
    .group_size_i(gsize), .tbl_we_i(tbl_we), .tbl_addr_i(taddr),
    .tbl_data_i(tdata), .busy_o(busy), .valid_o(valid), .hash_o(hash),
    .member_o(member));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_hash();
    logic [191:0] k;
    logic [7:0] h;
    k = {en[0] ? dmac : 48'h0, en[0] ? smac : 48'h0, en[1] ? dip : 32'h0,
         en[1] ? sip : 32'h0, en[2] ? dport : 16'h0, en[2] ? sport : 16'h0};
    h = 8'h0;
    for (int i = 0; i < KEY_BYTES; i++) h = m_fwd[h ^ k[191 - 8*i -: 8]];
    return h;
  endfunction

  function automatic logic [3:0] model_member(input logic [7:0] h);
    logic [7:0] mk;
    int sz;
    mk = (hbits >= 8) ? 8'hFF : 8'((1 << hbits) - 1);
    sz = (gsize > 16) ? 16 : int'(gsize);
    if (sz <= 1) return 4'h0;
    return 4'(int'(h & mk) % sz);
  endfunction

  task automatic send(input logic [2:0] e, input logic [47:0] dm, sm,
                      input logic [31:0] di, si, input logic [15:0] dp, sp,
                      input logic [3:0] b, input logic [4:0] s, input string tag);
    exp_t x;
    @(negedge clk);
    while (busy) @(negedge clk);
    en = e; dmac = dm; smac = sm; dip = di; sip = si; dport = dp; sport = sp;
    hbits = b; gsize = s; req = 1;
    x.h = model_hash(); x.m = model_member(x.h); x.acc = cyc + 1; x.tag = tag;
    sb.push_back(x);
    @(negedge clk);
    req = 0;
  endtask

  // write applied to the model only when issued while idle (R7, R8)
  task automatic tbl_write(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] ov, op;
    @(negedge clk);
    tbl_we = 1; taddr = a; tdata = d;
    if (!busy) begin
      ov = m_fwd[a]; op = m_inv[d];
      m_fwd[op] = ov; m_fwd[a] = d; m_inv[ov] = op; m_inv[d] = a;
    end
    @(negedge clk);
    tbl_we = 0;
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n && valid) begin
    if (sb.size() == 0) begin
      check(0, "R9 unexpected result", 1, 0);
    end else begin
      exp_t x;
      x = sb.pop_front();
      check(hash == x.h, {x.tag, " R2 hash"}, hash, x.h);
      check(member == x.m, {x.tag, " R6 member"}, member, x.m);
      check(cyc - x.acc == KEY_BYTES, {x.tag, " R4 latency"}, cyc - x.acc, KEY_BYTES);
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    check(0, "watchdog", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] h_first;
    logic [3:0] m_first;
    for (int i = 0; i < 256; i++) begin m_fwd[i] = 8'(i); m_inv[i] = 8'(i); end
    repeat (3) @(negedge clk);
    check(!busy && !valid, "R1 idle after reset", {busy, valid}, 0);
    check(hash == 8'h0, "R1 hash after reset", hash, 0);
    rst_n = 1;

    // R1/R2: identity table gives XOR of key bytes
    send(3'b111, 48'h0011_2233_4455, 48'hA0B1_C2D3_E4F5, 32'hC0A8_0001, 32'h0A00_0002,
         16'd443, 16'd51000, 4'd8, 5'd16, "R1 identity");
    send(3'b111, 48'hDEAD_BEEF_0001, 48'h0102_0304_0506, 32'h1020_3040, 32'h5060_7080,
         16'd80, 16'd1234, 4'd4, 5'd7, "R2 basic");
    // R3 field enables
    send(3'b001, 48'hDEAD_BEEF_0001, 48'h0102_0304_0506, 32'h1020_3040, 32'h5060_7080,
         16'd80, 16'd1234, 4'd8, 5'd16, "R3 l2 only");
    send(3'b010, 48'hDEAD_BEEF_0001, 48'h0102_0304_0506, 32'h1020_3040, 32'h5060_7080,
         16'd80, 16'd1234, 4'd8, 5'd16, "R3 l3 only");
    send(3'b100, 48'hDEAD_BEEF_0001, 48'h0102_0304_0506, 32'h1020_3040, 32'h5060_7080,
         16'd80, 16'd1234, 4'd8, 5'd16, "R3 l4 only");
    send(3'b000, 48'hDEAD_BEEF_0001, 48'h0102_0304_0506, 32'h1020_3040, 32'h5060_7080,
         16'd80, 16'd1234, 4'd8, 5'd16, "R3 none");

    // R7: swap writes, then hash with permuted table
    tbl_write(8'h00, 8'h5A);
    tbl_write(8'h13, 8'hC7);
    tbl_write(8'h5A, 8'h13);
    for (int i = 1; i < 40; i++) tbl_write(8'(i * 37), 8'(i * 11 + 3));
    send(3'b000, 48'h0, 48'h0, 32'h0, 32'h0, 16'h0, 16'h0, 4'd8, 5'd16, "R7 zero key");
    send(3'b111, 48'h0011_2233_4455, 48'hA0B1_C2D3_E4F5, 32'hC0A8_0001, 32'h0A00_0002,
         16'd443, 16'd51000, 4'd8, 5'd13, "R7 permuted");

    // R5 hash bits
    send(3'b111, 48'h0011_2233_4455, 48'hA0B1_C2D3_E4F5, 32'hC0A8_0001, 32'h0A00_0002,
         16'd443, 16'd51000, 4'd0, 5'd9, "R5 zero bits");
    send(3'b111, 48'h0011_2233_4455, 48'hA0B1_C2D3_E4F5, 32'hC0A8_0001, 32'h0A00_0002,
         16'd443, 16'd51000, 4'd3, 5'd5, "R5 three bits");
    send(3'b111, 48'h0011_2233_4455, 48'hA0B1_C2D3_E4F5, 32'hC0A8_0001, 32'h0A00_0002,
         16'd443, 16'd51000, 4'd15, 5'd11, "R5 clamp bits");
    // R6 group sizes
    send(3'b111, 48'h7777_0000_1234, 48'h0, 32'hFFFF_FFFF, 32'h0, 16'd9, 16'd9,
         4'd8, 5'd1, "R6 size one");
    send(3'b111, 48'h7777_0000_1234, 48'h0, 32'hFFFF_FFFF, 32'h0, 16'd9, 16'd9,
         4'd8, 5'd0, "R6 size zero");
    send(3'b111, 48'h7777_0000_1234, 48'h0, 32'hFFFF_FFFF, 32'h0, 16'd9, 16'd9,
         4'd8, 5'd31, "R6 size clamp");

    // R8/R9: write and request during busy are ignored
    send(3'b111, 48'h1111_2222_3333, 48'h4444_5555_6666, 32'h0102_0304, 32'h0506_0708,
         16'd22, 16'd60000, 4'd8, 5'd16, "R8 R9 busy");
    @(negedge clk);
    check(busy == 1'b1, "R4 busy during hash", busy, 1);
    tbl_write(8'h01, 8'hEE);
    @(negedge clk);
    req = 1; dmac = 48'hFFFF_FFFF_FFFF;
    @(negedge clk);
    req = 0;
    // R10 repeat: same key and config, compare to first result too
    send(3'b111, 48'h1111_2222_3333, 48'h4444_5555_6666, 32'h0102_0304, 32'h0506_0708,
         16'd22, 16'd60000, 4'd8, 5'd16, "R10 repeat");
    @(negedge clk);
    while (busy) @(negedge clk);
    h_first = hash; m_first = member;
    send(3'b111, 48'h1111_2222_3333, 48'h4444_5555_6666, 32'h0102_0304, 32'h0506_0708,
         16'd22, 16'd60000, 4'd8, 5'd16, "R10 again");
    @(negedge clk);
    while (busy) @(negedge clk);
    check(hash == h_first, "R10 same hash", hash, h_first);
    check(member == m_first, "R10 same member", member, m_first);

    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R4 all results seen", sb.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule